// File: doc/BRIEF.md
# Interprocessor Message Destination Router

This block takes one interprocessor message header at a time and decides which of `NUM_TGT` target interrupt controllers should receive it. A header carries the sender index, an 8-bit destination field, a bit choosing physical or logical addressing, a 2-bit shorthand and a flag for lowest-priority delivery. Each target presents its physical ID, its logical ID, a 4-bit addressing-model nibble and an enable flag on plain, quasi-static inputs.

For ordinary delivery the result is the mask of every target whose address matched. For lowest-priority delivery the block keeps a rotating pointer and returns exactly one target: the first enabled match found after the previously chosen one. The header enters on a valid/ready port and the result leaves on a valid/ready port. Only one result register sits between them, so `req_ready` is high whenever the result register is empty or is being drained in the same cycle. A result stays unchanged while `out_valid` is high and `out_ready` is low. The payload itself does not pass through the block.

Top module: `ipi_route_sel`

## Requirements
- R1: Shorthand 1 (self) selects only the target whose index equals `req_src`, and ignores the destination field and the mode bit.
- R2: Shorthand 2 (all) selects every target, including the sender.
- R3: Shorthand 3 (all others) selects every target except the sender.
- R4: With shorthand 0 and `req_logical`=0 (physical), a target matches when `req_dest` equals its physical ID, or when `req_dest` is 8'hFF.
- R5: With shorthand 0, `req_logical`=1 and a target model nibble of 4'hF (flat), the target matches when its logical ID ANDed with `req_dest` is nonzero.
- R6: With shorthand 0, `req_logical`=1 and a model nibble of 4'h0 (cluster), the target matches when bits 7:4 of its logical ID equal bits 7:4 of `req_dest` and the AND of bits 3:0 of the two is nonzero.
- R7: A logical-mode message never matches a target whose model nibble is neither 4'hF nor 4'h0.
- R8: When `req_lowpri`=1, `out_mask` holds exactly one bit: the first target in the order prev+1, prev+2, … (wrapping at `NUM_TGT`, prev itself last) that matched and has `tgt_enable`=1. That index becomes the new prev. After reset prev is `NUM_TGT`-1, so the first search starts at target 0.
- R9: When `req_lowpri`=1 and no matching target is enabled, `out_mask` is zero, `out_none` is 1 and prev is left unchanged.
- R10: When `req_lowpri`=0, `out_mask` is the full match mask regardless of `tgt_enable`. `out_none` is 1 exactly when that mask is zero.
- R11: A header is taken on a clock edge where `req_valid` and `req_ready` are both high, and its result is presented with `out_valid`=1 from the next cycle on. `req_ready` equals `!out_valid || out_ready`. While `out_valid`=1 and `out_ready`=0, `out_mask` and `out_none` hold their values.
- R12: After reset, `out_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Header valid |
| req_ready | output | 1 | Header accepted when high with req_valid |
| req_src | input | SRC_W | Sender target index |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 0 physical, 1 logical addressing |
| req_shorthand | input | 2 | 0 field, 1 self, 2 all, 3 all but sender |
| req_lowpri | input | 1 | Lowest-priority delivery: pick one target |
| tgt_phys_id | input | NUM_TGT*8 | Physical ID of target i in bits 8i+7:8i |
| tgt_log_id | input | NUM_TGT*8 | Logical ID of target i in bits 8i+7:8i |
| tgt_model | input | NUM_TGT*4 | Model nibble of target i in bits 4i+3:4i |
| tgt_enable | input | NUM_TGT | Target enable flags |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed when high with out_valid |
| out_mask | output | NUM_TGT | Selected targets |
| out_none | output | 1 | No target selected |

## Verification
The hardest situation to reach from the ports is the wrap-around of the lowest-priority search. The pointer has to sit near the top index while the only enabled candidates lie below it, and also the case where the single remaining candidate is the previous pick itself. A directed sequence steers the pointer there by issuing several lowest-priority broadcasts in turn with chosen enable patterns, then narrows the enables to force a wrap and a self re-pick. Random headers and random configurations follow, with random back-pressure on the result port.

// File: rtl/ipi_route_pkg.sv
package ipi_route_pkg;
  localparam int ID_W  = 8;
  localparam int MDL_W = 4;

  typedef enum logic [1:0] {
    SH_FIELD  = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [MDL_W-1:0] MODEL_FLAT    = 4'hF;
  localparam logic [MDL_W-1:0] MODEL_CLUSTER = 4'h0;
  localparam logic [ID_W-1:0]  DEST_BCAST    = 8'hFF;
endpackage

// File: rtl/ipi_addr_match.sv
module ipi_addr_match
  import ipi_route_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int SRC_W = 3
) (
  input  logic [SRC_W-1:0] src,
  input  logic [ID_W-1:0]  dest,
  input  logic             logical,
  input  logic [1:0]       shorthand,
  input  logic [ID_W-1:0]  phys_id,
  input  logic [ID_W-1:0]  log_id,
  input  logic [MDL_W-1:0] model,
  output logic             hit
);
  localparam logic [SRC_W-1:0] MY_IDX = SRC_W'(IDX);
  localparam int HALF = ID_W / 2;

  logic is_self;
  logic phys_hit;
  logic flat_hit;
  logic clus_hit;
  logic log_hit;

  always_comb begin
    is_self  = (src == MY_IDX);
    phys_hit = (dest == phys_id) || (dest == DEST_BCAST);
    flat_hit = |(log_id & dest);
    clus_hit = (log_id[ID_W-1:HALF] == dest[ID_W-1:HALF]) &&
               (|(log_id[HALF-1:0] & dest[HALF-1:0]));
    unique case (model)
      MODEL_FLAT:    log_hit = flat_hit;
      MODEL_CLUSTER: log_hit = clus_hit;
      default:       log_hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (shorthand_e'(shorthand))
      SH_FIELD:  hit = logical ? log_hit : phys_hit;
      SH_SELF:   hit = is_self;
      SH_ALL:    hit = 1'b1;
      SH_OTHERS: hit = !is_self;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int NUM_TGT = 8,
  parameter int SRC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_TGT-1:0] cand,
  input  logic               advance,
  output logic [NUM_TGT-1:0] pick,
  output logic               pick_hit
);
  localparam logic [SRC_W-1:0] LAST = SRC_W'(NUM_TGT - 1);

  logic [SRC_W-1:0] prev_q;
  logic [SRC_W-1:0] pick_idx;

  always_comb begin
    pick     = '0;
    pick_hit = 1'b0;
    pick_idx = prev_q;
    for (int off = 1; off <= NUM_TGT; off++) begin
      int j;
      j = int'(prev_q) + off;
      if (j >= NUM_TGT) j = j - NUM_TGT;
      if (!pick_hit && cand[j]) begin
        pick_hit = 1'b1;
        pick_idx = SRC_W'(j);
        pick[j]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  prev_q <= LAST;
    else if (advance && pick_hit) prev_q <= pick_idx;
  end

  // R8
  prev_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(prev_q) < NUM_TGT);

  // R8
  pick_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_hit |-> ((pick & cand) == pick) && $onehot(pick));

  // R9
  prev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !pick_hit) |=> $stable(prev_q));
endmodule

// File: rtl/ipi_route_sel.sv
module ipi_route_sel
  import ipi_route_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int SRC_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [SRC_W-1:0]         req_src,
  input  logic [7:0]               req_dest,
  input  logic                     req_logical,
  input  logic [1:0]               req_shorthand,
  input  logic                     req_lowpri,
  input  logic [NUM_TGT*8-1:0]     tgt_phys_id,
  input  logic [NUM_TGT*8-1:0]     tgt_log_id,
  input  logic [NUM_TGT*4-1:0]     tgt_model,
  input  logic [NUM_TGT-1:0]       tgt_enable,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NUM_TGT-1:0]       out_mask,
  output logic                     out_none
);
  logic [NUM_TGT-1:0] hit;
  logic [NUM_TGT-1:0] cand;
  logic [NUM_TGT-1:0] pick;
  logic               pick_hit;
  logic [NUM_TGT-1:0] next_mask;
  logic               take;
  logic               lowpri_q;

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    ipi_addr_match #(.IDX(t), .SRC_W(SRC_W)) u_match (
      .src       (req_src),
      .dest      (req_dest),
      .logical   (req_logical),
      .shorthand (req_shorthand),
      .phys_id   (tgt_phys_id[t*ID_W +: ID_W]),
      .log_id    (tgt_log_id[t*ID_W +: ID_W]),
      .model     (tgt_model[t*MDL_W +: MDL_W]),
      .hit       (hit[t])
    );
  end

  assign cand = hit & tgt_enable;

  ipi_rr_pick #(.NUM_TGT(NUM_TGT), .SRC_W(SRC_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .cand     (cand),
    .advance  (take && req_lowpri),
    .pick     (pick),
    .pick_hit (pick_hit)
  );

  assign req_ready = !out_valid || out_ready;
  assign take      = req_valid && req_ready;
  assign next_mask = req_lowpri ? pick : hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_none  <= 1'b0;
      lowpri_q  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_mask  <= next_mask;
      out_none  <= ~|next_mask;
      lowpri_q  <= req_lowpri;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mask) && $stable(out_none)));

  // R8
  lowpri_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && lowpri_q) |-> $onehot0(out_mask));

  // R9
  none_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_none) |-> (out_mask == '0));

  // R2
  bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_lowpri && req_shorthand == 2'd2) |=> (out_mask == {NUM_TGT{1'b1}}));

  // R12
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/ipi_route_sel_test.sv
module ipi_route_sel_test;
  localparam int N  = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_ready;
  logic [SW-1:0] req_src = '0;
  logic [7:0] req_dest = '0;
  logic req_logical = 1'b0;
  logic [1:0] req_shorthand = '0;
  logic req_lowpri = 1'b0;
  logic [N*8-1:0] tgt_phys_id, tgt_log_id;
  logic [N*4-1:0] tgt_model;
  logic [N-1:0] tgt_enable = '1;
  logic out_valid, out_ready = 1'b0;
  logic [N-1:0] out_mask;
  logic out_none;

  logic [7:0] pid [N];
  logic [7:0] lid [N];
  logic [3:0] mdl [N];

  always_comb begin
    for (int t = 0; t < N; t++) begin
      tgt_phys_id[t*8 +: 8] = pid[t];
      tgt_log_id[t*8 +: 8]  = lid[t];
      tgt_model[t*4 +: 4]   = mdl[t];
    end
  end

  ipi_route_sel #(.NUM_TGT(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dest(req_dest), .req_logical(req_logical),
    .req_shorthand(req_shorthand), .req_lowpri(req_lowpri),
    .tgt_phys_id(tgt_phys_id), .tgt_log_id(tgt_log_id), .tgt_model(tgt_model),
    .tgt_enable(tgt_enable), .out_valid(out_valid), .out_ready(out_ready),
    .out_mask(out_mask), .out_none(out_none)
  );

  int total = 0;
  int bad = 0;
  int prev_m = N - 1;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit tgt_hit(int t, int src, logic [7:0] d, bit lg, logic [1:0] sh);
    case (sh)
      2'd1: return t == src;
      2'd2: return 1'b1;
      2'd3: return t != src;
      default: begin
        if (!lg) return (d == pid[t]) || (d == 8'hFF);
        if (mdl[t] == 4'hF) return (lid[t] & d) != 0;
        if (mdl[t] == 4'h0) return (lid[t][7:4] == d[7:4]) && ((lid[t][3:0] & d[3:0]) != 0);
        return 1'b0;
      end
    endcase
  endfunction

  task automatic send(input int src, input logic [7:0] d, input bit lg, input logic [1:0] sh,
                      input bit lp, input int hold, input string req);
    logic [N-1:0] m;
    logic [N-1:0] exp;
    bit found;
    for (int t = 0; t < N; t++) m[t] = tgt_hit(t, src, d, lg, sh);
    exp = m;
    if (lp) begin
      exp = '0;
      found = 0;
      for (int off = 1; off <= N; off++) begin
        int j;
        j = (prev_m + off) % N;
        if (!found && m[j] && tgt_enable[j]) begin
          found = 1;
          exp[j] = 1'b1;
          prev_m = j;
        end
      end
    end
    @(negedge clk);
    req_src = SW'(src); req_dest = d; req_logical = lg; req_shorthand = sh; req_lowpri = lp;
    req_valid = 1'b1; out_ready = 1'b0;
    check(req_ready == 1'b1, "R11 ready when empty", 32'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(out_valid == 1'b1, "R11 valid after accept", 32'(out_valid), 1);
    check(out_mask == exp, req, 32'(out_mask), 32'(exp));
    check(out_none == (exp == '0), {req, " none"}, 32'(out_none), 32'(exp == '0));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(out_valid && out_mask == exp && !req_ready, "R11 held under back-pressure",
            32'(out_mask), 32'(exp));
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11 drained", 32'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20250);
    for (int t = 0; t < N; t++) begin
      pid[t] = 8'(t * 3 + 1);
      lid[t] = 8'(1 << t);
      mdl[t] = 4'hF;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0 && req_ready == 1'b1, "R12 reset state", 32'(out_valid), 0);
    rst_n = 1'b1;

    send(2, 8'h00, 0, 2'd1, 0, 0, "R1 self");
    send(5, 8'hFF, 1, 2'd1, 0, 0, "R1 self ignores dest");
    send(3, 8'h00, 0, 2'd2, 0, 2, "R2 all");
    send(3, 8'h00, 0, 2'd3, 0, 0, "R3 all others");
    send(0, 8'd10, 0, 2'd0, 0, 0, "R4 physical id");
    send(0, 8'hFF, 0, 2'd0, 0, 0, "R4 physical broadcast");
    send(0, 8'h99, 0, 2'd0, 0, 0, "R10 empty mask");
    send(0, 8'h25, 1, 2'd0, 0, 0, "R5 flat");
    for (int t = 0; t < N; t++) begin
      lid[t] = {(t < 4) ? 4'h1 : 4'h2, 4'(1 << (t % 4))};
      mdl[t] = 4'h0;
    end
    send(0, 8'h1B, 1, 2'd0, 0, 0, "R6 cluster");
    send(0, 8'h26, 1, 2'd0, 0, 0, "R6 other cluster");
    mdl[1] = 4'h5; mdl[3] = 4'hE;
    send(0, 8'h1F, 1, 2'd0, 0, 0, "R7 bad model");
    send(0, 8'h03, 0, 2'd0, 0, 0, "R7 physical unaffected");
    tgt_enable = 8'b0000_0000;
    send(1, 8'h00, 0, 2'd2, 0, 0, "R10 enable ignored");
    send(1, 8'h00, 0, 2'd2, 1, 0, "R9 no candidate");
    tgt_enable = 8'b1010_0110;
    send(1, 8'h00, 0, 2'd2, 1, 1, "R8 first pick");
    send(1, 8'h00, 0, 2'd2, 1, 0, "R8 next pick");
    send(1, 8'h00, 0, 2'd2, 1, 0, "R8 next pick");
    send(1, 8'h00, 0, 2'd2, 1, 0, "R8 wrap pick");
    tgt_enable = 8'b0000_0100;
    send(1, 8'h00, 0, 2'd2, 1, 0, "R8 sole candidate");
    send(1, 8'h00, 0, 2'd2, 1, 0, "R8 repick previous");
    send(2, 8'h00, 0, 2'd3, 1, 0, "R9 excluded sender");

    for (int k = 0; k < 400; k++) begin
      if (k % 25 == 0) begin
        for (int t = 0; t < N; t++) begin
          pid[t] = 8'($urandom_range(0, 15));
          lid[t] = 8'($urandom);
          case ($urandom_range(0, 3))
            0: mdl[t] = 4'h0;
            1: mdl[t] = 4'hF;
            2: mdl[t] = 4'hF;
            default: mdl[t] = 4'($urandom);
          endcase
        end
        tgt_enable = N'($urandom);
      end
      send($urandom_range(0, N - 1),
           ($urandom_range(0, 9) == 0) ? 8'hFF : 8'($urandom_range(0, 255)),
           1'($urandom), 2'(($urandom_range(0, 3) == 0) ? $urandom : 0),
           1'($urandom), $urandom_range(0, 2), "R4 R5 R6 R8 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule